// File: doc/BRIEF.md
# MOESI Snooping Line Controller

This block keeps a small writeback cache coherent with other caches that share one snooping bus. Every line carries one of five states: Modified, Owned, Exclusive, Shared or Invalid. Processor loads and stores are served locally when the state allows it. Otherwise the block raises one bus request at a time and holds it until the bus answers. The request is a read, a read-exclusive, a data-less upgrade, or a writeback of a dirty victim.

The same block watches the transactions that other agents put on the bus. It reports whether it holds a copy of the line. When it holds the dirty copy it drives the line data in place of memory. It then moves the line to Owned, Shared or Invalid according to the snooped command. The shared indication collected from the other agents decides whether a read miss fills the line as Exclusive or as Shared.

The storage is a direct-mapped array of `LINES` one-word lines. The low address bits select the line and the remaining bits form the tag. A combinational probe port reports the coherence state that the cache holds for any address. This lets a system-level checker compare the states of several caches.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_ready` and `bus_req_valid` are low.
- R2: `peek_state` gives the state of the line holding `peek_addr`, encoded Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4. It gives 0 when the tag does not match.
- R3: A load that misses issues a bus read (command code 0). The line fills as Exclusive when `bus_resp_shared` is low and as Shared when it is high. The returned word appears on `cpu_rdata`.
- R4: A store to an absent or Invalid line issues a read-exclusive (code 1). The line ends Modified and holds the stored word.
- R5: A store to a Shared or Owned line issues an upgrade (code 2), and the line becomes Modified with the stored word once the bus answers.
- R6: A load that hits, or a store to a Modified or Exclusive line, raises no bus request and pulses `cpu_ready` one cycle after acceptance. The store leaves the line Modified.
- R7: A snooped read (code 0) that hits a Modified line raises `snp_supply` with the line's data, and the line becomes Owned without any writeback. An Owned line supplies again and stays Owned.
- R8: A snooped read that hits an Exclusive line moves it to Shared, with `snp_shared` high and `snp_supply` low.
- R9: A snooped read-exclusive or upgrade that hits a valid line moves it to Invalid. Modified and Owned lines supply data for a read-exclusive, and an upgrade never causes a supply.
- R10: A miss whose indexed line is Modified or Owned first writes that line back (code 3) with its own address and data, then fetches. A Shared or Exclusive victim is dropped with no writeback.
- R11: A snooped writeback command (code 3) leaves every line unchanged and raises neither `snp_shared` nor `snp_supply`.
- R12: When a snoop arrives in the same cycle as a processor request, the snoop is applied first. The processor request is then served against the updated state.
- R13: If a snoop invalidates a line while that line's upgrade is still pending, the pending command becomes read-exclusive. The store then completes with the line Modified.
- R14: Across two controllers on one bus, a line is never held in Modified, Owned or Exclusive by both. Owned is held only alongside Shared or Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_ready` |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| bus_req_addr | output | ADDR_W | Address of the pending request |
| bus_req_data | output | DATA_W | Writeback data |
| bus_resp_valid | input | 1 | Completion of the pending request |
| bus_resp_shared | input | 1 | Another cache holds the line (read fill) |
| bus_resp_data | input | DATA_W | Fill data |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as `bus_req_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache drives the line data instead of memory |
| snp_data | output | DATA_W | Supplied data |
| peek_addr | input | ADDR_W | Address whose state is reported |
| peek_state | output | 3 | Coherence state of `peek_addr` |

## Verification
The bench targets the Modified-to-Owned hand-off. A design that wrote memory or dropped ownership there would show a writeback or return the stale memory word to the second reader. Upgrades from Owned and Shared are checked against silent stores: a design that classified stores wrongly would either skip the invalidation of the other copy or waste a read-exclusive. A snoop that collides with a processor request, and a snoop that invalidates a line with an upgrade in flight, are both provoked. A wrong priority shows up as a silent store on a line that was just shared, and a missing conversion leaves a Modified line built on lost data. Evictions are checked for a writeback of dirty victims only, and every step ends with a pairwise state check across both caches.

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_resp_valid,
  input  logic              bus_resp_shared,
  input  logic [DATA_W-1:0] bus_resp_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [2:0]        peek_state
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_WB, PH_FILL} phase_t;

  logic [2:0]        st [LINES];
  logic [TAG_W-1:0]  tg [LINES];
  logic [DATA_W-1:0] dt [LINES];
  phase_t            ph;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [2:0]       c_st  = st[c_idx];
  wire             c_hit = c_st != ST_I && tg[c_idx] == c_tag;
  wire             c_dirty = c_st == ST_M || c_st == ST_O;
  wire             c_wperm = c_st == ST_M || c_st == ST_E;

  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];
  wire [2:0]       s_st  = st[s_idx];
  wire             s_hit = snp_valid && s_st != ST_I && tg[s_idx] == s_tag;
  wire             s_act = s_hit && snp_cmd != C_WB;
  wire             s_kill = s_act && snp_cmd != C_RD;

  wire [IDX_W-1:0] p_idx = peek_addr[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = peek_addr[ADDR_W-1:IDX_W];

  wire accept = ph == PH_IDLE && cpu_req && !cpu_ready && !snp_valid;

  assign snp_shared = s_act;
  assign snp_supply = s_act && snp_cmd != C_UPG && (s_st == ST_M || s_st == ST_O);
  assign snp_data   = snp_supply ? dt[s_idx] : '0;
  assign peek_state = (tg[p_idx] == p_tag) ? st[p_idx] : ST_I;

  function automatic logic [2:0] snoop_next(input logic [2:0] s, input logic [1:0] c);
    case (c)
      C_RD:    return (s == ST_M) ? ST_O : (s == ST_E) ? ST_S : s;
      C_RDX,
      C_UPG:   return ST_I;
      default: return s;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i] <= ST_I;
        tg[i] <= '0;
        dt[i] <= '0;
      end
      ph            <= PH_IDLE;
      cpu_ready     <= 1'b0;
      cpu_rdata     <= '0;
      bus_req_valid <= 1'b0;
      bus_req_cmd   <= C_RD;
      bus_req_addr  <= '0;
      bus_req_data  <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (ph)
        PH_IDLE: if (accept) begin
          if (c_hit && !cpu_we) begin
            cpu_rdata <= dt[c_idx];
            cpu_ready <= 1'b1;
          end else if (c_hit && c_wperm) begin
            dt[c_idx] <= cpu_wdata;
            st[c_idx] <= ST_M;
            cpu_ready <= 1'b1;
          end else if (c_hit) begin
            bus_req_valid <= 1'b1;
            bus_req_cmd   <= C_UPG;
            bus_req_addr  <= cpu_addr;
            ph            <= PH_FILL;
          end else if (c_dirty) begin
            bus_req_valid <= 1'b1;
            bus_req_cmd   <= C_WB;
            bus_req_addr  <= {tg[c_idx], c_idx};
            bus_req_data  <= dt[c_idx];
            ph            <= PH_WB;
          end else begin
            st[c_idx]     <= ST_I;
            bus_req_valid <= 1'b1;
            bus_req_cmd   <= cpu_we ? C_RDX : C_RD;
            bus_req_addr  <= cpu_addr;
            ph            <= PH_FILL;
          end
        end
        PH_WB: if (bus_resp_valid) begin
          st[c_idx]    <= ST_I;
          bus_req_cmd  <= cpu_we ? C_RDX : C_RD;
          bus_req_addr <= cpu_addr;
          ph           <= PH_FILL;
        end
        PH_FILL: begin
          if (bus_resp_valid) begin
            bus_req_valid <= 1'b0;
            ph            <= PH_IDLE;
            cpu_ready     <= 1'b1;
            tg[c_idx]     <= c_tag;
            if (bus_req_cmd == C_RD) begin
              st[c_idx] <= bus_resp_shared ? ST_S : ST_E;
              dt[c_idx] <= bus_resp_data;
              cpu_rdata <= bus_resp_data;
            end else begin
              st[c_idx] <= ST_M;
              dt[c_idx] <= cpu_wdata;
            end
          end else if (bus_req_cmd == C_UPG && s_kill && s_idx == c_idx) begin
            bus_req_cmd <= C_RDX;
          end
        end
        default: ph <= PH_IDLE;
      endcase
      if (s_act) st[s_idx] <= snoop_next(s_st, snp_cmd);
    end
  end

  AST_SNOOP_RD_M_TO_O: assert property (@(posedge clk) disable iff (!rst_n)
    s_hit && snp_cmd == C_RD && s_st == ST_M |=> st[$past(s_idx)] == ST_O) else $error("M line not owned after snooped read"); // R7

  AST_SNOOP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    s_hit && (snp_cmd == C_RDX || snp_cmd == C_UPG) |=> st[$past(s_idx)] == ST_I) else $error("line survived snooped invalidation"); // R9

  AST_SILENT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && c_hit && cpu_we && c_wperm |=> cpu_ready && !bus_req_valid) else $error("store with write permission went to bus"); // R6

  AST_UPG_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_FILL && bus_resp_valid && bus_req_cmd == C_UPG && !snp_valid |=> st[$past(c_idx)] == ST_M) else $error("upgrade did not grant Modified"); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_resp_valid |=> bus_req_valid && $stable(bus_req_addr)) else $error("bus request withdrawn"); // R10

  for (genvar gi = 0; gi < LINES; gi++) begin : g_dirty_chk
    AST_DIRTY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (st[gi] == ST_M || st[gi] == ST_O)
      && !(s_kill && s_idx == IDX_W'(gi))
      && !(ph == PH_WB && bus_resp_valid && c_idx == IDX_W'(gi))
      |=> st[gi] != ST_I) else $error("dirty line dropped without writeback"); // R10
  end
endmodule

// File: tb/test_moesi_snoop_ctrl.sv
module test_moesi_snoop_ctrl;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cpu_req[2], cpu_we[2], cpu_ready[2];
  logic [AW-1:0] cpu_addr[2];
  logic [DW-1:0] cpu_wdata[2], cpu_rdata[2];
  logic          bus_req_valid[2], bus_resp_valid[2], bus_resp_shared[2];
  logic [1:0]    bus_req_cmd[2], snp_cmd[2];
  logic [AW-1:0] bus_req_addr[2], snp_addr[2], peek_addr[2];
  logic [DW-1:0] bus_req_data[2], bus_resp_data[2], snp_data[2];
  logic          snp_valid[2], snp_shared[2], snp_supply[2];
  logic [2:0]    peek_state[2];

  for (genvar g = 0; g < 2; g++) begin : g_agent
    moesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) i_moesi_snoop_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req[g]), .cpu_we(cpu_we[g]), .cpu_addr(cpu_addr[g]), .cpu_wdata(cpu_wdata[g]),
      .cpu_ready(cpu_ready[g]), .cpu_rdata(cpu_rdata[g]),
      .bus_req_valid(bus_req_valid[g]), .bus_req_cmd(bus_req_cmd[g]),
      .bus_req_addr(bus_req_addr[g]), .bus_req_data(bus_req_data[g]),
      .bus_resp_valid(bus_resp_valid[g]), .bus_resp_shared(bus_resp_shared[g]),
      .bus_resp_data(bus_resp_data[g]),
      .snp_valid(snp_valid[g]), .snp_cmd(snp_cmd[g]), .snp_addr(snp_addr[g]),
      .snp_shared(snp_shared[g]), .snp_supply(snp_supply[g]), .snp_data(snp_data[g]),
      .peek_addr(peek_addr[g]), .peek_state(peek_state[g]));
  end

  logic [DW-1:0] mem [256];
  int n_chk = 0, n_bad = 0;
  logic [1:0] cmd_log [8];
  int cmd_n, wb_n = 0;
  bit sup_seen;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic peek(input int ag, input logic [AW-1:0] a, output logic [2:0] s);
    peek_addr[ag] = a;
    #1;
    s = peek_state[ag];
  endtask

  task automatic expect_state(input int ag, input logic [AW-1:0] a, input logic [2:0] e, input string req);
    logic [2:0] s;
    peek(ag, a, s);
    chk_eq(req, {29'd0, s}, {29'd0, e});
  endtask

  function automatic bit pair_ok(input logic [2:0] a, input logic [2:0] b);
    if (a > 3'd4 || b > 3'd4) return 1'b0;
    if (a == 3'd0 || b == 3'd0) return 1'b1;
    return (a == 3'd1 && b == 3'd1) || (a == 3'd1 && b == 3'd3) || (a == 3'd3 && b == 3'd1);
  endfunction

  task automatic check_pair(input logic [AW-1:0] a);
    logic [2:0] sa, sb;
    peek(0, a, sa);
    peek(1, a, sb);
    chk(pair_ok(sa, sb), "R14 pairwise states", {26'd0, sa, sb}, 32'd0);
  endtask

  task automatic serve(input int ag);
    int o = 1 - ag;
    logic [1:0] c = bus_req_cmd[ag];
    logic [AW-1:0] a = bus_req_addr[ag];
    logic sh, sp;
    logic [DW-1:0] sd;
    if (cmd_n < 8) cmd_log[cmd_n] = c;
    cmd_n++;
    snp_valid[o] = 1'b1; snp_cmd[o] = c; snp_addr[o] = a;
    #1;
    sh = snp_shared[o]; sp = snp_supply[o]; sd = snp_data[o];
    if (sp) sup_seen = 1'b1;
    if (c == 2'd3) begin
      mem[a] = bus_req_data[ag];
      wb_n++;
    end
    @(negedge clk);
    snp_valid[o] = 1'b0;
    bus_resp_valid[ag] = 1'b1;
    bus_resp_shared[ag] = sh;
    bus_resp_data[ag] = sp ? sd : mem[a];
    @(negedge clk);
    bus_resp_valid[ag] = 1'b0;
  endtask

  task automatic start_op(input int ag, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    cpu_req[ag] = 1'b1; cpu_we[ag] = we; cpu_addr[ag] = a; cpu_wdata[ag] = wd;
    cmd_n = 0; sup_seen = 1'b0;
  endtask

  task automatic finish_op(input int ag, output logic [DW-1:0] rd);
    int guard = 0;
    @(negedge clk);
    while (!cpu_ready[ag] && guard < 100) begin
      guard++;
      if (bus_req_valid[ag]) serve(ag);
      else @(negedge clk);
    end
    rd = cpu_rdata[ag];
    cpu_req[ag] = 1'b0;
    cpu_we[ag] = 1'b0;
  endtask

  task automatic op(input int ag, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                    output logic [DW-1:0] rd);
    @(negedge clk);
    start_op(ag, we, a, wd);
    finish_op(ag, rd);
  endtask

  task automatic t_reset;
    logic [2:0] s;
    for (int g = 0; g < 2; g++) begin
      peek(g, 8'h10, s);
      chk_eq("R1 reset line invalid", {29'd0, s}, 32'd0);
      chk_eq("R1 reset ready low", {31'd0, cpu_ready[g]}, 32'd0);
      chk_eq("R1 reset no request", {31'd0, bus_req_valid[g]}, 32'd0);
    end
  endtask

  task automatic t_read_fills;
    logic [DW-1:0] rd;
    op(0, 0, 8'h10, '0, rd);
    chk_eq("R3 read miss data", rd, 32'hC0DE_0010);
    chk_eq("R3 one bus request", cmd_n, 1);
    chk_eq("R3 command is read", {30'd0, cmd_log[0]}, 32'd0);
    expect_state(0, 8'h10, 3'd2, "R3 R2 alone fills Exclusive");
    op(1, 0, 8'h10, '0, rd);
    chk_eq("R3 shared read data", rd, 32'hC0DE_0010);
    chk_eq("R8 Exclusive does not supply", {31'd0, sup_seen}, 32'd0);
    expect_state(1, 8'h10, 3'd1, "R3 fills Shared when another holds it");
    expect_state(0, 8'h10, 3'd1, "R8 snooped Exclusive becomes Shared");
    check_pair(8'h10);
  endtask

  task automatic t_upgrade_and_silent;
    logic [DW-1:0] rd;
    op(0, 1, 8'h10, 32'h1111_1111, rd);
    chk_eq("R5 store to Shared is upgrade", {30'd0, cmd_log[0]}, 32'd2);
    chk_eq("R9 upgrade never supplies", {31'd0, sup_seen}, 32'd0);
    expect_state(0, 8'h10, 3'd4, "R5 upgrade ends Modified");
    expect_state(1, 8'h10, 3'd0, "R9 snooped upgrade invalidates");
    op(0, 1, 8'h10, 32'h2222_2222, rd);
    chk_eq("R6 store to Modified is silent", cmd_n, 0);
    op(0, 0, 8'h10, '0, rd);
    chk_eq("R6 read hit silent", cmd_n, 0);
    chk_eq("R6 read hit data", rd, 32'h2222_2222);
    check_pair(8'h10);
  endtask

  task automatic t_owned;
    logic [DW-1:0] rd;
    op(1, 0, 8'h10, '0, rd);
    chk_eq("R7 Modified supplies to reader", rd, 32'h2222_2222);
    chk_eq("R7 supply seen", {31'd0, sup_seen}, 32'd1);
    chk_eq("R7 no writeback on sharing", wb_n, 0);
    chk_eq("R7 memory left stale", mem[8'h10], 32'hC0DE_0010);
    expect_state(0, 8'h10, 3'd3, "R7 Modified becomes Owned");
    expect_state(1, 8'h10, 3'd1, "R7 reader holds Shared");
    check_pair(8'h10);
    op(1, 0, 8'h14, '0, rd);
    chk_eq("R10 Shared victim dropped silently", cmd_n, 1);
    chk_eq("R10 only a read issued", {30'd0, cmd_log[0]}, 32'd0);
    expect_state(1, 8'h14, 3'd2, "R3 unshared line Exclusive");
    expect_state(1, 8'h10, 3'd0, "R2 mismatched tag reports Invalid");
    op(1, 0, 8'h10, '0, rd);
    chk_eq("R7 Owned supplies again", rd, 32'h2222_2222);
    chk_eq("R10 Exclusive victim dropped silently", cmd_n, 1);
    expect_state(0, 8'h10, 3'd3, "R7 Owned stays Owned");
    check_pair(8'h10);
    op(0, 1, 8'h10, 32'h3333_3333, rd);
    chk_eq("R5 store to Owned is upgrade", {30'd0, cmd_log[0]}, 32'd2);
    expect_state(0, 8'h10, 3'd4, "R5 Owned upgrade ends Modified");
    expect_state(1, 8'h10, 3'd0, "R9 sharer invalidated");
    check_pair(8'h10);
  endtask

  task automatic t_rdx_and_evict;
    logic [DW-1:0] rd;
    op(1, 1, 8'h10, 32'h4444_4444, rd);
    chk_eq("R4 store to Invalid is read-exclusive", {30'd0, cmd_log[0]}, 32'd1);
    chk_eq("R9 Modified supplies on read-exclusive", {31'd0, sup_seen}, 32'd1);
    expect_state(1, 8'h10, 3'd4, "R4 ends Modified");
    expect_state(0, 8'h10, 3'd0, "R9 read-exclusive invalidates");
    check_pair(8'h10);
    op(1, 0, 8'h10, '0, rd);
    chk_eq("R4 stored word kept", rd, 32'h4444_4444);
    op(1, 0, 8'h20, '0, rd);
    chk_eq("R10 writeback then read", cmd_n, 2);
    chk_eq("R10 first command writeback", {30'd0, cmd_log[0]}, 32'd3);
    chk_eq("R10 second command read", {30'd0, cmd_log[1]}, 32'd0);
    chk_eq("R10 victim data in memory", mem[8'h10], 32'h4444_4444);
    chk_eq("R10 fill data", rd, 32'hC0DE_0020);
    expect_state(1, 8'h10, 3'd0, "R10 victim gone");
    expect_state(1, 8'h20, 3'd2, "R10 new line Exclusive");
  endtask

  task automatic t_wb_snoop;
    logic [DW-1:0] rd;
    op(0, 1, 8'h05, 32'h5555_5555, rd);
    chk_eq("R4 read-exclusive issued", {30'd0, cmd_log[0]}, 32'd1);
    check_pair(8'h05);
    @(negedge clk);
    snp_valid[0] = 1'b1; snp_cmd[0] = 2'd3; snp_addr[0] = 8'h05;
    #1;
    chk_eq("R11 writeback snoop no supply", {31'd0, snp_supply[0]}, 32'd0);
    chk_eq("R11 writeback snoop no shared", {31'd0, snp_shared[0]}, 32'd0);
    @(negedge clk);
    snp_valid[0] = 1'b0;
    expect_state(0, 8'h05, 3'd4, "R11 state unchanged");
    op(0, 0, 8'h05, '0, rd);
    chk_eq("R11 data unchanged", rd, 32'h5555_5555);
  endtask

  task automatic t_priority;
    logic [DW-1:0] rd;
    op(0, 0, 8'h0A, '0, rd);
    expect_state(0, 8'h0A, 3'd2, "R12 setup Exclusive");
    @(negedge clk);
    start_op(0, 1, 8'h0A, 32'h6666_6666);
    snp_valid[0] = 1'b1; snp_cmd[0] = 2'd0; snp_addr[0] = 8'h0A;
    #1;
    chk_eq("R8 snooped Exclusive reports shared", {31'd0, snp_shared[0]}, 32'd1);
    chk_eq("R8 snooped Exclusive no supply", {31'd0, snp_supply[0]}, 32'd0);
    @(negedge clk);
    snp_valid[0] = 1'b0;
    chk_eq("R12 request held back", {31'd0, cpu_ready[0] | bus_req_valid[0]}, 32'd0);
    expect_state(0, 8'h0A, 3'd1, "R12 snoop applied first");
    @(negedge clk);
    chk_eq("R12 request now valid", {31'd0, bus_req_valid[0]}, 32'd1);
    chk_eq("R12 store sees Shared so upgrades", {30'd0, bus_req_cmd[0]}, 32'd2);
    finish_op(0, rd);
    expect_state(0, 8'h0A, 3'd4, "R12 store completes Modified");
    op(0, 0, 8'h0A, '0, rd);
    chk_eq("R12 stored data", rd, 32'h6666_6666);
  endtask

  task automatic t_convert;
    logic [DW-1:0] rd;
    op(0, 0, 8'h0B, '0, rd);
    op(1, 0, 8'h0B, '0, rd);
    check_pair(8'h0B);
    @(negedge clk);
    start_op(0, 1, 8'h0B, 32'h7777_7777);
    @(negedge clk);
    chk_eq("R13 upgrade pending", {30'd0, bus_req_cmd[0]}, 32'd2);
    snp_valid[0] = 1'b1; snp_cmd[0] = 2'd1; snp_addr[0] = 8'h0B;
    #1;
    chk_eq("R9 Shared never supplies", {31'd0, snp_supply[0]}, 32'd0);
    @(negedge clk);
    snp_valid[0] = 1'b0;
    chk_eq("R13 converted to read-exclusive", {30'd0, bus_req_cmd[0]}, 32'd1);
    expect_state(0, 8'h0B, 3'd0, "R13 line lost while pending");
    finish_op(0, rd);
    expect_state(0, 8'h0B, 3'd4, "R13 ends Modified");
    expect_state(1, 8'h0B, 3'd0, "R13 other copy invalidated");
    check_pair(8'h0B);
    op(0, 0, 8'h0B, '0, rd);
    chk_eq("R13 stored data", rd, 32'h7777_7777);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d cycles expected fewer", 20000);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | i;
    for (int g = 0; g < 2; g++) begin
      cpu_req[g] = 0; cpu_we[g] = 0; cpu_addr[g] = '0; cpu_wdata[g] = '0;
      bus_resp_valid[g] = 0; bus_resp_shared[g] = 0; bus_resp_data[g] = '0;
      snp_valid[g] = 0; snp_cmd[g] = '0; snp_addr[g] = '0; peek_addr[g] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_fills();
    t_upgrade_and_silent();
    t_owned();
    t_rdx_and_evict();
    t_wb_snoop();
    t_priority();
    t_convert();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule